// File: doc/BRIEF.md
# Generation-Tagged Event Queue Writer

This block appends 32-bit event words to a circular queue that lives in external memory. It holds one queue descriptor in registers: a base address, a 4-bit size code, the current slot index, a generation bit and a generation-flipped flag. Software loads the descriptor through a load strobe. The queue holds 2^(size code + 10) slots of 4 bytes each.

Each accepted push produces exactly one memory write request over a valid/ready request channel. The block then waits for a single response. The stored word replaces the top bit of the event with the current generation bit. The generation bit toggles each time the index wraps to zero, so a consumer can tell fresh slots from stale ones without sharing a read pointer. A write that completes with an error is reported, and the descriptor is left unchanged.

Top module: `gen_queue_writer`

## Requirements
- R1: After reset, busy, mem_req_valid, wr_err and cfg_err are low, and the descriptor outputs (base, size, index, gen, gen_flipped) are all zero.
- R2: A cfg_load with cfg_size not above MAX_SIZE_CODE replaces the descriptor, and the new value is visible the cycle after the load. A larger size code raises cfg_err for one cycle and leaves the descriptor unchanged. A cfg_load that arrives while busy is high is ignored.
- R3: The write address is q_base + 4 * q_index, sampled when the push is accepted.
- R4: The stored word is {q_gen, push_data[30:0]}, so bit 31 of the event is dropped. It is placed on mem_req_data in big-endian byte order: stored bits 31:24 go to mem_req_data[7:0] and stored bits 7:0 go to mem_req_data[31:24].
- R5: After a response without error, q_index advances by one, modulo 2^(q_size + 10).
- R6: When the advanced index wraps to 0, q_gen inverts and q_gen_flipped takes the new q_gen value.
- R7: A response with mem_rsp_err high raises wr_err for one cycle and leaves q_index, q_gen and q_gen_flipped unchanged.
- R8: push_ready is low from the cycle after a push is accepted until the response has been consumed, and while cfg_load is high. Only one write is outstanding at any time.
- R9: Once mem_req_valid is asserted, it stays high with stable address and data until mem_req_ready.
- R10: On a load, cfg_index is reduced modulo the entry count of the new size code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Descriptor load strobe |
| cfg_base | input | ADDR_W | Queue base address to load |
| cfg_size | input | 4 | Size code to load |
| cfg_index | input | IDX_W | Starting slot index to load |
| cfg_gen | input | 1 | Starting generation bit to load |
| cfg_err | output | 1 | One-cycle pulse when a size code is rejected |
| push_valid | input | 1 | Event push request |
| push_data | input | 32 | Event word |
| push_ready | output | 1 | Push accepted when high with push_valid |
| mem_req_valid | output | 1 | Memory write request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | ADDR_W | Byte address of the write |
| mem_req_data | output | 32 | Big-endian stored word |
| mem_rsp_valid | input | 1 | Write response |
| mem_rsp_err | input | 1 | Response reports an error |
| busy | output | 1 | A write is in flight |
| wr_err | output | 1 | One-cycle pulse on an error response |
| q_base | output | ADDR_W | Current base address |
| q_size | output | 4 | Current size code |
| q_index | output | IDX_W | Current slot index |
| q_gen | output | 1 | Current generation bit |
| q_gen_flipped | output | 1 | Generation-flipped flag |

## Verification
On every cycle, the in-line assertions check three things: the request hold rule, the single-outstanding rule, and that the index stays inside the entry count. They also check that an error response freezes the descriptor and that an out-of-range size code is rejected. Only the bench's scenarios can show the rest, because each needs a model of the queue over several pushes. This covers the computed addresses, the byte order and the generation tagging of the data, the exact wrap point for different size codes, and the generation flip seen in the data that follows a wrap. It also covers configuration loads that are ignored while a write is in flight.

// File: rtl/gen_queue_writer.sv
module gen_queue_writer #(
  parameter int ADDR_W = 32,
  parameter int MAX_SIZE_CODE = 4,
  localparam int IDX_W = MAX_SIZE_CODE + 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [3:0]        cfg_size,
  input  logic [IDX_W-1:0]  cfg_index,
  input  logic              cfg_gen,
  output logic              cfg_err,
  input  logic              push_valid,
  input  logic [31:0]       push_data,
  output logic              push_ready,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_data,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  output logic              busy,
  output logic              wr_err,
  output logic [ADDR_W-1:0] q_base,
  output logic [3:0]        q_size,
  output logic [IDX_W-1:0]  q_index,
  output logic              q_gen,
  output logic              q_gen_flipped
);

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_REQ  = 2'd1;
  localparam logic [1:0] ST_RSP  = 2'd2;

  logic [1:0]       state;
  logic [IDX_W:0]   cur_span, cfg_span;
  logic [IDX_W-1:0] cur_mask, cfg_mask, idx_next;
  logic [31:0]      stored;
  logic             accept, cfg_take, cfg_bad, rsp_take;

  assign cur_span = {{IDX_W{1'b0}}, 1'b1} << ({1'b0, q_size} + 5'd10);
  assign cfg_span = {{IDX_W{1'b0}}, 1'b1} << ({1'b0, cfg_size} + 5'd10);
  assign cur_mask = IDX_W'(cur_span - 1'b1);
  assign cfg_mask = IDX_W'(cfg_span - 1'b1);
  assign idx_next = (q_index + 1'b1) & cur_mask;

  assign busy       = (state != ST_IDLE);
  assign push_ready = !busy && !cfg_load;
  assign accept     = push_valid && push_ready;
  assign cfg_take   = cfg_load && !busy;
  assign cfg_bad    = cfg_size > 4'(MAX_SIZE_CODE);
  assign rsp_take   = (state == ST_RSP) && mem_rsp_valid;
  assign mem_req_valid = (state == ST_REQ);

  assign stored = {q_gen, push_data[30:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      mem_req_addr  <= '0;
      mem_req_data  <= '0;
      wr_err        <= 1'b0;
      cfg_err       <= 1'b0;
      q_base        <= '0;
      q_size        <= '0;
      q_index       <= '0;
      q_gen         <= 1'b0;
      q_gen_flipped <= 1'b0;
    end else begin
      wr_err  <= 1'b0;
      cfg_err <= 1'b0;
      if (cfg_take) begin
        if (cfg_bad) begin
          cfg_err <= 1'b1;
        end else begin
          q_base        <= cfg_base;
          q_size        <= cfg_size;
          q_index       <= cfg_index & cfg_mask;
          q_gen         <= cfg_gen;
          q_gen_flipped <= 1'b0;
        end
      end
      case (state)
        ST_IDLE: if (accept) begin
          state        <= ST_REQ;
          mem_req_addr <= q_base + (ADDR_W'(q_index) << 2);
          mem_req_data <= {stored[7:0], stored[15:8], stored[23:16], stored[31:24]};
        end
        ST_REQ: if (mem_req_ready) state <= ST_RSP;
        ST_RSP: if (rsp_take) begin
          state <= ST_IDLE;
          if (mem_rsp_err) begin
            wr_err <= 1'b1;
          end else begin
            q_index <= idx_next;
            if (idx_next == '0) begin
              q_gen         <= !q_gen;
              q_gen_flipped <= !q_gen;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_ready |=> busy && mem_req_valid && !push_ready); // R8
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (({1'b0, q_index}) >> ({1'b0, q_size} + 5'd10)) == '0); // R5
  AST_ERR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && mem_rsp_err |=> wr_err && $stable(q_index) && $stable(q_gen) && $stable(q_gen_flipped)); // R7
  AST_WRAP_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take && !mem_rsp_err |=> ((q_index == '0) == (q_gen != $past(q_gen))) && (q_index != '0 || q_gen_flipped == q_gen)); // R6
  AST_CFG_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load && !busy && cfg_size > 4'(MAX_SIZE_CODE) |=> cfg_err && $stable(q_size) && $stable(q_base)); // R2

endmodule

// File: tb/test_gen_queue_writer.sv
module test_gen_queue_writer;
  localparam int ADDR_W = 32;
  localparam int MAXS = 4;
  localparam int IDX_W = MAXS + 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 1'b0;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [3:0] cfg_size = '0;
  logic [IDX_W-1:0] cfg_index = '0;
  logic cfg_gen = 1'b0;
  logic cfg_err;
  logic push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic push_ready;
  logic mem_req_valid;
  logic mem_req_ready = 1'b0;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [31:0] mem_req_data;
  logic mem_rsp_valid = 1'b0;
  logic mem_rsp_err = 1'b0;
  logic busy, wr_err;
  logic [ADDR_W-1:0] q_base;
  logic [3:0] q_size;
  logic [IDX_W-1:0] q_index;
  logic q_gen, q_gen_flipped;

  always #4 clk = ~clk;

  gen_queue_writer #(.ADDR_W(ADDR_W), .MAX_SIZE_CODE(MAXS)) i_gen_queue_writer (.*);

  int checks = 0;
  int errors = 0;
  logic [63:0] exp_q[$];
  int stall = 0, lat = 0;
  bit inj_err = 0, poke_cfg = 0, done = 0;

  logic [ADDR_W-1:0] m_base = '0;
  logic [3:0] m_size = '0;
  logic [IDX_W-1:0] m_idx = '0;
  logic m_gen = 0, m_flip = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] swap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [IDX_W-1:0] mask_of(input logic [3:0] s);
    return IDX_W'(({{IDX_W{1'b0}}, 1'b1} << (s + 10)) - 1);
  endfunction

  // monitor: memory model and scoreboard
  initial begin
    logic [ADDR_W-1:0] a0;
    logic [31:0] d0;
    logic [63:0] e;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        a0 = mem_req_addr; d0 = mem_req_data;
        for (int i = 0; i < stall; i++) begin
          if (poke_cfg && i == 0) begin
            cfg_base = 32'hDEAD_0000; cfg_size = 4'd1; cfg_load = 1'b1;
          end
          @(negedge clk);
          cfg_load = 1'b0;
          check(!push_ready, "R8 ready low while busy", push_ready, 0);
          check(mem_req_addr == a0 && mem_req_data == d0, "R9 request held", mem_req_addr, a0);
        end
        mem_req_ready = 1'b1;
        e = exp_q.pop_front();
        check(mem_req_addr == e[63:32], "R3 address", mem_req_addr, e[63:32]);
        check(mem_req_data == e[31:0], "R4 data", mem_req_data, e[31:0]);
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        mem_rsp_valid = 1'b1; mem_rsp_err = inj_err;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
      end
    end
  end

  task automatic check_desc(input string req);
    check(q_index == m_idx, req, q_index, m_idx);
    check(q_gen == m_gen && q_gen_flipped == m_flip, req, {q_gen, q_gen_flipped}, {m_gen, m_flip});
  endtask

  task automatic load(input logic [ADDR_W-1:0] b, input logic [3:0] s, input logic [IDX_W-1:0] ix, input logic g);
    @(negedge clk);
    cfg_base = b; cfg_size = s; cfg_index = ix; cfg_gen = g; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    if (s > MAXS) begin
      check(cfg_err == 1'b1, "R2 bad size pulses cfg_err", cfg_err, 1);
      check(q_size == m_size && q_base == m_base, "R2 bad size keeps descriptor", q_size, m_size);
    end else begin
      m_base = b; m_size = s; m_idx = ix & mask_of(s); m_gen = g; m_flip = 0;
      check(cfg_err == 1'b0 && q_base == b && q_size == s, "R2 load", q_base, b);
      check_desc("R10 loaded index reduced");
    end
  endtask

  task automatic push(input logic [31:0] d, input bit err);
    inj_err = err;
    exp_q.push_back({m_base + (ADDR_W'(m_idx) << 2), swap({m_gen, d[30:0]})});
    @(negedge clk);
    push_valid = 1'b1; push_data = d;
    while (!push_ready) @(negedge clk);
    @(negedge clk);
    push_valid = 1'b0;
    while (busy) @(negedge clk);
    check(wr_err == err, "R7 wr_err pulse", wr_err, err);
    if (!err) begin
      m_idx = (m_idx + 1'b1) & mask_of(m_size);
      if (m_idx == '0) begin m_gen = !m_gen; m_flip = m_gen; end
      check_desc("R5 R6 descriptor after write");
    end else begin
      check_desc("R7 descriptor frozen on error");
    end
    @(negedge clk);
    check(wr_err == 1'b0, "R7 wr_err one cycle", wr_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_req_valid && !wr_err && !cfg_err && push_ready, "R1 reset controls", busy, 0);
    check(q_base == 0 && q_size == 0 && q_index == 0 && !q_gen && !q_gen_flipped, "R1 reset descriptor", q_index, 0);
    load(32'h1000_0000, 4'd0, 14'd5, 1'b0);
    push(32'h8123_4567, 0);
    push(32'h0000_00FF, 0);
    stall = 3; lat = 2;
    push(32'hFFFF_FFFF, 0);
    push(32'h1234_5678, 1);
    stall = 2; lat = 0; poke_cfg = 1;
    push(32'hA5A5_5A5A, 0);
    poke_cfg = 0;
    check(q_base == m_base && q_size == m_size, "R2 load ignored while busy", q_base, m_base);
    stall = 0;
    load(32'h2000_0000, 4'd0, 14'd1022, 1'b1);
    push(32'h0000_0001, 0);
    push(32'h0000_0002, 0);
    push(32'h0000_0003, 0);
    load(32'h3000_0000, 4'd1, 14'h3FFE, 1'b0);
    push(32'h7000_0000, 0);
    push(32'h7000_0001, 0);
    push(32'h7000_0002, 0);
    load(32'h4000_0000, 4'd9, 14'd3, 1'b0);
    load(32'h5000_0000, 4'd4, 14'h3FFF, 1'b1);
    push(32'hCAFE_F00D, 1);
    push(32'hCAFE_F00E, 0);
    @(negedge clk);
    check(cfg_load == 0 && push_ready, "R8 ready after response", push_ready, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule